// File: doc/BRIEF.md
# Servo Status Packet Parser

This block interprets a reply frame that a servo has returned over a half-duplex serial line. The serial receiver writes the frame into a byte-wide buffer RAM, starting at address 0. When the frame is complete, the controller raises `parse_en`. The parser then reads the frame back one byte at a time through a read port that it shares with other agents. It has the lowest priority on that port, so a read only takes place in a cycle where `rd_grant` is high. Each byte arrives one cycle after its read is accepted.

A frame is made of two sync bytes of value 0xFF, the servo identifier, a count byte, the servo's fault byte, zero or more payload bytes and a closing check byte. The parser checks the sync bytes, checks that the count is within range and checks the check byte. It then publishes the identifier, the fault byte and a single "servo reports a fault" summary. On request it also publishes a 10-bit joint position taken from the payload.

`busy` is high for as long as a frame is being examined, and its falling edge marks the end. `err_flag` is valid from that edge on. Acting on the individual fault bits is left to the logic that uses the outputs.

Top module: `servo_status_parser`

## Requirements
- R1: After reset, `busy`, `err_flag`, `servo_fault` and `rd_req` are low, and `servo_id`, `status_byte` and `angle` are zero.
- R2: When `parse_en` is high while idle, `busy` rises on the next edge. Reads then start at address 0 and step up by one for each granted read. With the grant held high and no pause, `busy` stays high for L+6 cycles, where L is the count byte (byte 3).
- R3: If byte 0 or byte 1 is not 0xFF, the parse ends with `err_flag` high. No address above 3 is read, and `servo_id`, `status_byte` and `angle` keep their previous values.
- R4: If the count byte L is below 2, or L-2 exceeds MAX_PARAMS, the parse ends after byte 3 with `err_flag` high. `servo_id`, `status_byte` and `angle` keep their previous values.
- R5: The check byte sits at address L+3 and must equal the bitwise inverse of the low 8 bits of the sum of bytes 2 through L+2. A mismatch raises `err_flag`.
- R6: During a parse with a valid count, addresses 0 through L+3 are each read exactly once, in ascending order, and nothing beyond L+3 is requested.
- R7: Whenever the count byte is valid, `servo_id` takes byte 2 and `status_byte` takes byte 4 at the end of the parse, even if the check byte fails.
- R8: `want_angle` is sampled at the start of a parse. If it was high, a count other than 4 raises `err_flag`. On a clean parse `angle` becomes {byte 6 bits 1..0, byte 5}, the low byte coming first in the frame. The upper six bits of byte 6 are discarded. Otherwise `angle` is left unchanged.
- R9: `servo_fault` is the OR of `status_byte` bits 0 to 6. These bits are, in order: supply voltage out of range, target outside the angle limits, over-temperature, command out of range, corrupted command, insufficient torque and unknown command. Bit 7 carries no meaning and has no effect.
- R10: While `parse_en` is low, `rd_req` stays low. A parse that is paused in this way and then resumed gives the same result as one that was never paused.
- R11: `rd_req` is held until a cycle with `rd_grant` high. Only such a cycle advances the address, so any grant pattern gives the same result.
- R12: After `busy` falls, the parser does not start again while `parse_en` stays high. A new parse needs `parse_en` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| parse_en | input | 1 | Start and run permission for parsing |
| want_angle | input | 1 | Request decoding of the 2-byte position payload |
| rd_req | output | 1 | Read request to the shared buffer RAM |
| rd_addr | output | ADDR_W | Byte address of the requested read |
| rd_grant | input | 1 | Arbiter grant for the current request |
| rd_data | input | 8 | RAM data, one cycle after a granted read |
| busy | output | 1 | High while a frame is being examined |
| err_flag | output | 1 | Bad sync, count, check byte or payload size |
| servo_id | output | 8 | Identifier of the replying servo |
| status_byte | output | 8 | Fault byte reported by the servo |
| servo_fault | output | 1 | Any of fault bits 0 to 6 set |
| angle | output | 10 | Decoded joint position, 0 to 1023 |

## Verification
The bench builds the parser with MAX_PARAMS set to 4. This makes the full range of count values reachable in one sweep: the too-short counts 0 and 1, every legal payload size from 0 to 4 bytes, and the first count that is too large. The sweep crosses every count with both values of the position request, three grant patterns (always granted, every second cycle, every third cycle) and four corruptions (none, either sync byte, check byte). The fault byte cycles through each single bit, including the meaningless bit 7. Runs with a valid count also include a mid-parse pause of the enable. The cycle count of `busy` is compared against L+6 whenever the grant is held high.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;

    // Frame layout: fixed byte positions used by the parser
    localparam logic [7:0] SYNC_BYTE  = 8'hFF;
    localparam int         POS_ID     = 2;
    localparam int         POS_COUNT  = 3;
    localparam int         POS_FAULT  = 4;
    localparam int         POS_PAY0   = 5;
    localparam int         POS_PAY1   = 6;
    localparam int         COUNT_MIN  = 2;   // count = payload bytes + 2
    localparam int         ANGLE_CNT  = 4;   // count of a 2-byte position reply

    // Meaningful fault bits are 0..6; bit 7 is ignored
    localparam logic [7:0] FAULT_MASK = 8'h7F;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic fin;
        logic bad;
    } verdict_t;

    function automatic logic [7:0] check_of(input logic [7:0] running_sum);
        return ~running_sum;
    endfunction

    function automatic logic [9:0] angle_of(input logic [7:0] lo, input logic [1:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/sp_fetch.sv
`timescale 1ns/1ps
module sp_fetch #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              run_en,
    input  logic              count_known,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              grant,
    input  logic [7:0]        rdata,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              byte_vld,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [7:0]        byte_data
);
    localparam logic [IDX_W-1:0] COUNT_IDX = IDX_W'(sp_pkg::POS_COUNT);

    logic [IDX_W-1:0] next_idx;
    logic [IDX_W-1:0] pend_idx;
    logic             pending;
    logic             in_window;
    logic             fire;

    // Until the count byte has been seen, never read past it
    always_comb begin
        if (count_known) in_window = (next_idx <= last_idx);
        else             in_window = (next_idx <= COUNT_IDX);
    end

    assign req  = active && run_en && in_window;
    assign fire = req && grant;
    assign addr = ADDR_W'(next_idx);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            next_idx <= '0;
        end else if (fire) begin
            next_idx <= next_idx + 1'b1;
        end
    end

    // One cycle of RAM read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            pend_idx <= '0;
        end else begin
            pending <= fire;
            if (fire) pend_idx <= next_idx;
        end
    end

    assign byte_vld  = pending;
    assign byte_idx  = pend_idx;
    assign byte_data = rdata;

    AST_FETCH_GRANT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (req && !grant && !start) |=> $stable(next_idx)); // R11

endmodule

// File: rtl/sp_check.sv
`timescale 1ns/1ps
module sp_check
    import sp_pkg::*;
#(
    parameter int MAX_PARAMS = 8,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic             want_ang,
    output logic             count_known,
    output logic [IDX_W-1:0] last_idx,
    output logic [7:0]       id_q,
    output logic [7:0]       fault_q,
    output logic [9:0]       ang_q,
    output verdict_t         verdict
);
    localparam logic [IDX_W-1:0] I_SYNC1 = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_ID    = IDX_W'(POS_ID);
    localparam logic [IDX_W-1:0] I_CNT   = IDX_W'(POS_COUNT);
    localparam logic [IDX_W-1:0] I_FLT   = IDX_W'(POS_FAULT);
    localparam logic [IDX_W-1:0] I_P0    = IDX_W'(POS_PAY0);
    localparam logic [IDX_W-1:0] I_P1    = IDX_W'(POS_PAY1);
    localparam int               CNT_MAX = MAX_PARAMS + COUNT_MIN;

    logic [7:0] run_sum;
    logic [7:0] count_q;
    logic [7:0] pay_lo;
    logic [1:0] pay_hi;
    logic       count_ok;
    logic       at_check;
    logic       summed;

    assign count_ok = (int'(data) >= COUNT_MIN) && (int'(data) <= CNT_MAX);
    assign last_idx = IDX_W'(count_q) + I_CNT;
    assign at_check = count_known && (idx == last_idx);
    assign summed   = vld && (idx >= I_ID) && !at_check;

    always_comb begin
        verdict = '0;
        if (vld) begin
            if (idx <= I_SYNC1 && data != SYNC_BYTE) begin
                verdict.fin = 1'b1;
                verdict.bad = 1'b1;
            end else if (idx == I_CNT && !count_ok) begin
                verdict.fin = 1'b1;
                verdict.bad = 1'b1;
            end else if (at_check) begin
                verdict.fin = 1'b1;
                verdict.bad = (data != check_of(run_sum)) ||
                              (want_ang && int'(count_q) != ANGLE_CNT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            run_sum     <= '0;
            count_known <= 1'b0;
            count_q     <= '0;
        end else begin
            if (summed) run_sum <= run_sum + data;
            if (vld && idx == I_CNT) begin
                count_q     <= data;
                count_known <= count_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q    <= '0;
            fault_q <= '0;
            pay_lo  <= '0;
            pay_hi  <= '0;
        end else if (vld) begin
            if (idx == I_ID)  id_q    <= data;
            if (idx == I_FLT) fault_q <= data;
            if (idx == I_P0 && !at_check) pay_lo <= data;
            if (idx == I_P1 && !at_check) pay_hi <= data[1:0];
        end
    end

    assign ang_q = angle_of(pay_lo, pay_hi);

    AST_CHECK_SYNC_EARLY: assert property (@(posedge clk) disable iff (rst)
        (verdict.fin && !count_known) |-> (idx <= I_CNT)); // R3

endmodule

// File: rtl/sp_fault.sv
`timescale 1ns/1ps
module sp_fault (
    input  logic [7:0] status,
    output logic       any_fault
);
    // Bits 0..6: supply, angle limit, heat, range, corrupted command,
    // torque, unknown command. Bit 7 is masked away.
    assign any_fault = |(status & sp_pkg::FAULT_MASK);
endmodule

// File: rtl/servo_status_parser.sv
`timescale 1ns/1ps
module servo_status_parser
    import sp_pkg::*;
#(
    parameter int MAX_PARAMS = 8,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              parse_en,
    input  logic              want_angle,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_grant,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              err_flag,
    output logic [7:0]        servo_id,
    output logic [7:0]        status_byte,
    output logic              servo_fault,
    output logic [9:0]        angle
);
    localparam int IDX_W    = $clog2(MAX_PARAMS + 7);
    localparam int LAST_MAX = MAX_PARAMS + 5;

    phase_t           phase;
    logic             want_q;
    logic             start;
    logic             byte_vld;
    logic             vld_run;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       byte_data;
    logic             count_known;
    logic [IDX_W-1:0] last_idx;
    logic [7:0]       id_q;
    logic [7:0]       fault_q;
    logic [9:0]       ang_q;
    verdict_t         verdict;

    assign start   = (phase == PH_IDLE) && parse_en;
    assign busy    = (phase == PH_RUN);
    assign vld_run = byte_vld && busy;

    sp_fetch #(
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .active      (busy),
        .run_en      (parse_en),
        .count_known (count_known),
        .last_idx    (last_idx),
        .grant       (rd_grant),
        .rdata       (rd_data),
        .req         (rd_req),
        .addr        (rd_addr),
        .byte_vld    (byte_vld),
        .byte_idx    (byte_idx),
        .byte_data   (byte_data)
    );

    sp_check #(
        .MAX_PARAMS (MAX_PARAMS),
        .IDX_W      (IDX_W)
    ) u_check (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vld         (vld_run),
        .idx         (byte_idx),
        .data        (byte_data),
        .want_ang    (want_q),
        .count_known (count_known),
        .last_idx    (last_idx),
        .id_q        (id_q),
        .fault_q     (fault_q),
        .ang_q       (ang_q),
        .verdict     (verdict)
    );

    sp_fault u_fault (
        .status    (status_byte),
        .any_fault (servo_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            want_q      <= 1'b0;
            err_flag    <= 1'b0;
            servo_id    <= '0;
            status_byte <= '0;
            angle       <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (parse_en) begin
                        phase    <= PH_RUN;
                        want_q   <= want_angle;
                        err_flag <= 1'b0;
                    end
                end
                PH_RUN: begin
                    if (verdict.fin) begin
                        phase    <= PH_DONE;
                        err_flag <= verdict.bad;
                        if (count_known) begin
                            servo_id    <= id_q;
                            status_byte <= fault_q;
                        end
                        if (!verdict.bad && want_q) angle <= ang_q;
                    end
                end
                PH_DONE: begin
                    if (!parse_en) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (rd_addr == '0)); // R2

    AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr <= ADDR_W'(LAST_MAX))); // R6

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !parse_en |-> !rd_req); // R10

    AST_ANGLE_ON_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !$stable(angle) |-> (!busy && !err_flag)); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(err_flag) && $stable(servo_id) &&
                                     $stable(status_byte))); // R12

endmodule

// File: tb/servo_status_parser_bench.sv
`timescale 1ns/1ps
module servo_status_parser_bench;
    localparam int MAXP = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       parse_en;
    logic       want_angle;
    logic       rd_req;
    logic [7:0] rd_addr;
    logic       rd_grant;
    logic [7:0] rd_data;
    logic       busy;
    logic       err_flag;
    logic [7:0] servo_id;
    logic [7:0] status_byte;
    logic       servo_fault;
    logic [9:0] angle;

    int n_chk  = 0;
    int n_fail = 0;
    int gmode  = 0;
    int gcnt   = 0;
    int exp_next;
    int max_addr;
    int seq_err;
    int pause_err;
    logic [7:0] mem [0:15];

    always #5 clk = ~clk;

    servo_status_parser #(.MAX_PARAMS(MAXP), .ADDR_W(8)) u_servo_status_parser (
        .clk(clk), .rst(rst), .parse_en(parse_en), .want_angle(want_angle),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_grant(rd_grant), .rd_data(rd_data),
        .busy(busy), .err_flag(err_flag), .servo_id(servo_id),
        .status_byte(status_byte), .servo_fault(servo_fault), .angle(angle)
    );

    // Shared RAM with synchronous read, answered only when granted
    always @(posedge clk) if (rd_req && rd_grant) rd_data <= mem[rd_addr[3:0]];

    always @(negedge clk) gcnt <= gcnt + 1;
    always_comb begin
        case (gmode)
            0:       rd_grant = 1'b1;
            1:       rd_grant = gcnt[0];
            default: rd_grant = (gcnt % 3 == 0);
        endcase
    end

    // Port monitor, away from both edges
    always begin
        @(negedge clk);
        #2;
        if (rd_req && !parse_en) pause_err++;
        if (rd_req && rd_grant) begin
            if (int'(rd_addr) != exp_next) seq_err++;
            exp_next = int'(rd_addr) + 1;
            if (int'(rd_addr) > max_addr) max_addr = int'(rd_addr);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [7:0] e_id   = 8'h00;
    logic [7:0] e_stat = 8'h00;
    logic [9:0] e_ang  = 10'h000;

    task automatic run_pkt(input int seed, input int cnt, input bit want, input int corrupt,
                           input logic [7:0] fbyte, input bit pause);
        int np, cyc, bcnt;
        bit started, hdr_ok, cnt_ok, bad, exp_err;
        logic [7:0] sum;
        logic [7:0] pay [0:7];
        hdr_ok = (corrupt != 1) && (corrupt != 2);
        cnt_ok = (cnt >= 2) && (cnt <= MAXP + 2);
        np = cnt_ok ? cnt - 2 : 0;
        for (int i = 0; i < 16; i++) mem[i] = 8'((seed * 29 + i * 17) & 8'hFF);
        mem[0] = 8'hFF; mem[1] = 8'hFF;
        mem[2] = 8'((seed * 37 + 3) & 8'hFF);
        mem[3] = 8'(cnt);
        mem[4] = fbyte;
        for (int i = 0; i < 8; i++) pay[i] = 8'((seed * 13 + i * 71 + 5) & 8'hFF);
        for (int i = 0; i < np; i++) mem[5 + i] = pay[i];
        sum = mem[2] + mem[3] + mem[4];
        for (int i = 0; i < np; i++) sum = sum + pay[i];
        if (cnt_ok) mem[cnt + 3] = ~sum;
        if (corrupt == 1) mem[0] = 8'hFE;
        if (corrupt == 2) mem[1] = 8'h7F;
        if (corrupt == 3 && cnt_ok) mem[cnt + 3] = mem[cnt + 3] ^ 8'h01;
        if (!(hdr_ok && cnt_ok)) pause = 1'b0;

        bad     = (corrupt == 3) || (want && cnt != 4);
        exp_err = !hdr_ok || !cnt_ok || bad;
        if (hdr_ok && cnt_ok) begin
            e_id   = mem[2];
            e_stat = fbyte;
        end
        if (!exp_err && want) e_ang = {pay[1][1:0], pay[0]};

        exp_next = 0; max_addr = -1; seq_err = 0; pause_err = 0;
        want_angle = want;
        parse_en   = 1'b1;
        started = 0; cyc = 0; bcnt = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (pause && cyc == 3) parse_en = 1'b0;
            if (pause && cyc == 7) parse_en = 1'b1;
            if (busy) begin started = 1; bcnt++; end
            else if (started) break;
            if (cyc > 400) begin
                chk(0, "watchdog", cyc, 0);
                break;
            end
        end
        chk(err_flag == exp_err, "R3/R4/R5/R8 err_flag", err_flag, exp_err);
        chk(servo_id == e_id, "R7 servo_id", servo_id, e_id);
        chk(status_byte == e_stat, "R7 status_byte", status_byte, e_stat);
        chk(servo_fault == |e_stat[6:0], "R9 servo_fault", servo_fault, |e_stat[6:0]);
        chk(angle == e_ang, "R8 angle", angle, e_ang);
        if (!hdr_ok || !cnt_ok)
            chk(max_addr <= 3, "R3/R4 reads stop early", max_addr, 3);
        else
            chk(max_addr == cnt + 3, "R6 last address", max_addr, cnt + 3);
        chk(seq_err == 0, "R6/R11 ascending reads", seq_err, 0);
        chk(pause_err == 0, "R10 no request while paused", pause_err, 0);
        if (gmode == 0 && !pause && hdr_ok && cnt_ok)
            chk(bcnt == cnt + 6, "R2 busy length", bcnt, cnt + 6);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!busy, "R12 no restart while enable held", busy, 0);
        end
        parse_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int seed;
        logic [7:0] fb;
        rst = 1'b1; parse_en = 1'b0; want_angle = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R1 busy", busy, 0);
        chk(!err_flag, "R1 err_flag", err_flag, 0);
        chk(!rd_req, "R1 rd_req", rd_req, 0);
        chk(servo_id == 0 && status_byte == 0, "R1 id/status", {servo_id, status_byte}, 0);
        chk(angle == 0 && !servo_fault, "R1 angle/fault", angle, 0);
        seed = 0;
        for (int cnt = 0; cnt <= MAXP + 3; cnt++)
            for (int w = 0; w < 2; w++)
                for (int g = 0; g < 3; g++)
                    for (int c = 0; c < 4; c++) begin
                        seed++;
                        gmode = g;
                        fb = ((seed % 9) == 8) ? 8'h00 : 8'(1 << (seed % 9));
                        run_pkt(seed, cnt, w[0], c, fb, (seed % 3) == 0);
                    end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule